// File: doc/BRIEF.md
# Single-Stream DMA Engine with Byte-Packing FIFO

This block is one DMA stream. It copies a programmed number of data items from a source address to a destination address over a single-beat bus master port. Every access passes through a 16-byte internal FIFO that packs byte, halfword and word items. Three directions are supported: peripheral to memory, memory to peripheral, and memory to memory. Direction, per-side item size, per-side address increment, FIFO drain threshold, direct mode, circular reload and the request line are all set through a small register-write port.

Each bus access is first requested on `arb_req`. The access is placed on the master port only in a cycle where `arb_gnt` is high. A peripheral paces the stream through one of eight request lines, chosen by a 3-bit field. In memory to memory mode no request is needed.

When the programmed count of source items has been read and the FIFO has emptied, the stream raises a sticky completion flag. It then either stops or, in circular mode, reloads its pointers and count and runs again.

Top module: `dma_stream_fifo`

## Requirements
- R1: After a synchronous reset, `active`, `tc_flag`, `arb_req` and `mst_valid` are all low.
- R2: The CTRL register is written at address 3. Bits [15:13] of CTRL select one of the eight `per_req` lines. A rising edge on any line that is not selected starts no bus access.
- R3: Peripheral to memory (CTRL[2:1]=0) without direct mode reads one item per rising edge of the selected request. It makes no destination write until the FIFO holds at least (CTRL[12:11]+1)*4 bytes, then drains the FIFO to empty.
- R4: In direct mode (CTRL[10]=1, peripheral to memory), each item read is written to the destination before the next item is read.
- R5: Memory to peripheral (CTRL[2:1]=1) reads memory right after enable, with no request, until the 16-byte FIFO is full. Each selected request edge then causes exactly one item to be written to the peripheral.
- R6: Memory to memory (CTRL[2:1]=2) ignores requests. It fills the FIFO to the threshold, drains it, and repeats until done.
- R7: `mst_valid` is never high while `arb_gnt` is low. An `arb_req` that is not granted stays asserted.
- R8: The source address advances by the source item size after each read when CTRL[3]=1. The destination address advances by the destination item size after each write when CTRL[4]=1. Sizes are set by CTRL[6:5] and CTRL[8:7], with 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. When an increment bit is 0, that address stays fixed. Bytes are packed little-endian, and bus data is right-aligned.
- R9: Normal mode (CTRL[9]=0) reads the count programmed at address 2, waits for the FIFO to empty, then sets `tc_flag` and drops `active`. A count of 0 completes without any bus access.
- R10: Circular mode (CTRL[9]=1) sets `tc_flag`, reloads the addresses and the count, and keeps running. `tc_flag` stays high until a write to address 4. Writing CTRL with bit 0 low stops the stream.
- R11: While `active` is high, writes to address 0 (source), address 1 (destination) and address 2 (count) are ignored, and so are all CTRL fields. Only the stop request and the flag clear take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index: 0 source, 1 destination, 2 count, 3 control, 4 flag clear |
| cfg_wdata | input | 32 | Register write data |
| per_req | input | 8 | Peripheral request lines |
| arb_req | output | 1 | Stream wants a bus access |
| arb_gnt | input | 1 | Bus grant from the arbiter |
| mst_valid | output | 1 | Bus access presented this cycle |
| mst_write | output | 1 | 1 = write to destination, 0 = read from source |
| mst_addr | output | 32 | Byte address of the access |
| mst_size | output | 2 | Item size code of the access |
| mst_wdata | output | 32 | Right-aligned write data |
| mst_rdata | input | 32 | Right-aligned read data, sampled when the access completes |
| mst_ready | input | 1 | Access completes in this cycle |
| tc_flag | output | 1 | Sticky transfer-complete flag |
| active | output | 1 | Stream is running; low once it has really stopped |

## Verification
A wrong FIFO level or drain flag shows on the bus immediately as a change in the order of reads and writes. The bench records that order access by access and compares it to the expected fill and drain pattern for each threshold. A corrupted pointer or packing lane shows as wrong bytes at the destination once the run ends. A lost or phantom request shows within a few cycles of the request edge, as a missing or extra access on the master port. A bad count or bad reload logic shows as a completion flag that comes early or late, or as a stream that keeps running past its count.

// File: rtl/dma_stream_pkg.sv
package dma_stream_pkg;

  localparam int CH_W  = 3;
  localparam int N_REQ = 1 << CH_W;

  localparam logic [2:0] REG_SRC  = 3'd0;
  localparam logic [2:0] REG_DST  = 3'd1;
  localparam logic [2:0] REG_CNT  = 3'd2;
  localparam logic [2:0] REG_CTRL = 3'd3;
  localparam logic [2:0] REG_CLR  = 3'd4;

  typedef enum logic [1:0] {
    DIR_P2M = 2'd0,
    DIR_M2P = 2'd1,
    DIR_M2M = 2'd2
  } dir_e;

  // Packed from MSB: lands on cfg_wdata[15:1]
  typedef struct packed {
    logic [CH_W-1:0] chsel;
    logic [1:0]      thresh;
    logic            direct;
    logic            circ;
    logic [1:0]      dsize;
    logic [1:0]      ssize;
    logic            dinc;
    logic            sinc;
    dir_e            dir;
  } ctrl_t;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_byte_fifo.sv
module dma_byte_fifo #(
  parameter int DEPTH_BYTES = 16,
  parameter int DW          = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  logic [2:0]                   push_n,
  input  logic [DW-1:0]                din,
  input  logic                         pop,
  input  logic [2:0]                   pop_n,
  output logic [DW-1:0]                dout,
  output logic [$clog2(DEPTH_BYTES):0] level
);
  localparam int AW    = $clog2(DEPTH_BYTES);
  localparam int LW    = AW + 1;
  localparam int LANES = DW / 8;

  logic [7:0]    mem [DEPTH_BYTES];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push) begin
      for (int i = 0; i < LANES; i++) begin
        if (3'(i) < push_n) mem[wp + AW'(i)] <= din[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= wp + AW'(push_n);
      if (pop)  rp <= rp + AW'(pop_n);
      level <= level + (push ? LW'(push_n) : LW'(0)) - (pop ? LW'(pop_n) : LW'(0));
    end
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < LANES; i++) begin
      if (3'(i) < pop_n) dout[8*i +: 8] = mem[rp + AW'(i)];
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push && !pop |-> (level + LW'(push_n)) <= LW'(DEPTH_BYTES));

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> level >= LW'(pop_n));

endmodule

// File: rtl/dma_req_pick.sv
module dma_req_pick #(
  parameter int NREQ = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NREQ-1:0]          lines,
  input  logic [$clog2(NREQ)-1:0]  sel,
  output logic                     pulse
);
  logic s0, s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s0 <= 1'b0;
      s1 <= 1'b0;
    end else begin
      s0 <= lines[sel];
      s1 <= s0;
    end
  end

  assign pulse = s0 & ~s1;

endmodule

// File: rtl/dma_stream_fifo.sv
module dma_stream_fifo
  import dma_stream_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int FIFO_BYTES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic [N_REQ-1:0] per_req,
  output logic             arb_req,
  input  logic             arb_gnt,
  output logic             mst_valid,
  output logic             mst_write,
  output logic [AW-1:0]    mst_addr,
  output logic [1:0]       mst_size,
  output logic [31:0]      mst_wdata,
  input  logic [31:0]      mst_rdata,
  input  logic             mst_ready,
  output logic             tc_flag,
  output logic             active
);
  localparam int LW = $clog2(FIFO_BYTES) + 1;

  ctrl_t          ctrl;
  logic [AW-1:0]  src_base, dst_base, src_ptr, dst_ptr;
  logic [CW-1:0]  cnt_base, left, left_nx;
  logic           drain, pend, stop_req, req_pulse;
  logic [LW-1:0]  level, lvl_nx, sb, db, th_bytes, free;
  logic           rd_gate, wr_gate, rd_ok, wr_ok, do_rd, do_wr;
  logic           acc_done, push, pop, consume, start;

  dma_req_pick #(.NREQ(N_REQ)) u_pick (
    .clk(clk), .rst(rst), .lines(per_req), .sel(ctrl.chsel), .pulse(req_pulse)
  );

  assign sb       = LW'(size_bytes(ctrl.ssize));
  assign db       = LW'(size_bytes(ctrl.dsize));
  assign th_bytes = LW'((int'(ctrl.thresh) + 1) * 4);
  assign free     = LW'(FIFO_BYTES) - level;

  always_comb begin
    rd_gate = 1'b0;
    wr_gate = 1'b0;
    case (ctrl.dir)
      DIR_P2M: begin rd_gate = pend;   wr_gate = ctrl.direct | drain; end
      DIR_M2P: begin rd_gate = 1'b1;   wr_gate = pend;                end
      DIR_M2M: begin rd_gate = !drain; wr_gate = ctrl.direct | drain; end
      default: ;
    endcase
  end

  assign rd_ok = active && (left != '0) && (free >= sb) && rd_gate &&
                 (!ctrl.direct || ctrl.dir == DIR_M2P || level == '0);
  assign wr_ok = active && (level >= db) && wr_gate;
  assign do_wr = wr_ok;
  assign do_rd = rd_ok && !wr_ok;

  assign arb_req   = do_wr | do_rd;
  assign mst_valid = arb_req & arb_gnt;
  assign mst_write = do_wr;
  assign mst_addr  = do_wr ? dst_ptr : src_ptr;
  assign mst_size  = do_wr ? ctrl.dsize : ctrl.ssize;

  assign acc_done = mst_valid & mst_ready;
  assign push     = acc_done & ~mst_write;
  assign pop      = acc_done & mst_write;
  assign consume  = (ctrl.dir == DIR_P2M && push) || (ctrl.dir == DIR_M2P && pop);
  assign lvl_nx   = level + (push ? sb : LW'(0)) - (pop ? db : LW'(0));
  assign left_nx  = left - (push ? CW'(1) : CW'(0));
  assign start    = cfg_we && cfg_addr == REG_CTRL && !active && cfg_wdata[0];

  dma_byte_fifo #(.DEPTH_BYTES(FIFO_BYTES), .DW(32)) u_fifo (
    .clk(clk), .rst(rst), .flush(start),
    .push(push), .push_n(sb[2:0]), .din(mst_rdata),
    .pop(pop), .pop_n(db[2:0]), .dout(mst_wdata), .level(level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      src_base <= '0;
      dst_base <= '0;
      cnt_base <= '0;
      src_ptr  <= '0;
      dst_ptr  <= '0;
      left     <= '0;
      drain    <= 1'b0;
      pend     <= 1'b0;
      stop_req <= 1'b0;
      tc_flag  <= 1'b0;
      active   <= 1'b0;
    end else begin
      if (push) begin
        if (ctrl.sinc) src_ptr <= src_ptr + AW'(sb);
        left <= left_nx;
      end
      if (pop && ctrl.dinc) dst_ptr <= dst_ptr + AW'(db);
      pend  <= active && (req_pulse || (pend && !consume));
      drain <= active && lvl_nx != '0 &&
               (drain || lvl_nx >= th_bytes || left_nx == '0 ||
                (LW'(FIFO_BYTES) - lvl_nx) < sb);

      if (cfg_we) begin
        if (cfg_addr == REG_CLR) tc_flag <= 1'b0;
        if (!active) begin
          case (cfg_addr)
            REG_SRC:  src_base <= cfg_wdata[AW-1:0];
            REG_DST:  dst_base <= cfg_wdata[AW-1:0];
            REG_CNT:  cnt_base <= cfg_wdata[CW-1:0];
            REG_CTRL: ctrl     <= ctrl_t'(cfg_wdata[15:1]);
            default: ;
          endcase
        end else if (cfg_addr == REG_CTRL && !cfg_wdata[0]) begin
          stop_req <= 1'b1;
        end
      end

      if (start) begin
        active  <= 1'b1;
        src_ptr <= src_base;
        dst_ptr <= dst_base;
        left    <= cnt_base;
        drain   <= 1'b0;
        pend    <= 1'b0;
      end else if (active && left == '0 && level == '0) begin
        tc_flag <= 1'b1;
        if (ctrl.circ && !stop_req) begin
          src_ptr <= src_base;
          dst_ptr <= dst_base;
          left    <= cnt_base;
          drain   <= 1'b0;
        end else begin
          active   <= 1'b0;
          stop_req <= 1'b0;
        end
      end else if (active && stop_req && (!arb_req || acc_done)) begin
        active   <= 1'b0;
        stop_req <= 1'b0;
      end
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    arb_req && !arb_gnt |=> arb_req);

  // R11
  cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    active && cfg_we |=> $stable(ctrl) && $stable(src_base) &&
                         $stable(dst_base) && $stable(cnt_base));

  // R10
  tc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    tc_flag && !(cfg_we && cfg_addr == REG_CLR) |=> tc_flag);

  // R4
  direct_one_chk: assert property (@(posedge clk) disable iff (rst)
    active && ctrl.direct && ctrl.dir == DIR_P2M |-> level <= LW'(4));

endmodule

// File: tb/dma_stream_fifo_bench.sv
module dma_stream_fifo_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0]  per_req = '0;
  logic        arb_req, arb_gnt, mst_valid, mst_write, tc_flag, active;
  logic [31:0] mst_addr, mst_wdata, mst_rdata;
  logic [1:0]  mst_size;
  logic        mst_ready = 1'b1;
  logic        stall_mode = 1'b0;
  logic [1:0]  cyc = '0;

  int errors = 0, checks = 0;
  logic [7:0]  bmem [0:767];
  logic [31:0] plog [0:255];
  logic        oplog [0:255];
  int pn = 0, opn = 0, rd_cnt = 0, wr_cnt = 0, nogrant = 0, waitcyc = 0;
  logic [31:0] per_val = 32'hA000_0000;

  always #5 clk = ~clk;

  dma_stream_fifo u_dma_stream_fifo (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .per_req(per_req), .arb_req(arb_req), .arb_gnt(arb_gnt), .mst_valid(mst_valid),
    .mst_write(mst_write), .mst_addr(mst_addr), .mst_size(mst_size), .mst_wdata(mst_wdata),
    .mst_rdata(mst_rdata), .mst_ready(mst_ready), .tc_flag(tc_flag), .active(active)
  );

  assign arb_gnt = arb_req && (!stall_mode || cyc == 2'b00);

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [7:0] finit(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  function automatic logic [31:0] exp_word(input int a);
    return {finit(a+3), finit(a+2), finit(a+1), finit(a)};
  endfunction

  function automatic logic [31:0] rd_word(input int a);
    return {bmem[a+3], bmem[a+2], bmem[a+1], bmem[a]};
  endfunction

  always_comb begin
    mst_rdata = '0;
    if (mst_addr >= 32'd768) mst_rdata = per_val;
    else begin
      for (int i = 0; i < 4; i++)
        if (i < nbytes(mst_size) && int'(mst_addr) + i < 768)
          mst_rdata[8*i +: 8] = bmem[int'(mst_addr) + i];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 2'd1;
    if (!rst && arb_req && !arb_gnt) waitcyc <= waitcyc + 1;
    if (!rst && mst_valid && !arb_gnt) nogrant <= nogrant + 1;
    if (!rst && mst_valid && mst_ready) begin
      oplog[opn[7:0]] <= mst_write;
      opn <= opn + 1;
      if (mst_write) begin
        wr_cnt <= wr_cnt + 1;
        if (mst_addr >= 32'd768) begin
          plog[pn[7:0]] <= mst_wdata;
          pn <= pn + 1;
        end else begin
          for (int i = 0; i < 4; i++)
            if (i < nbytes(mst_size) && int'(mst_addr) + i < 768)
              bmem[int'(mst_addr) + i] <= mst_wdata[8*i +: 8];
        end
      end else begin
        rd_cnt <= rd_cnt + 1;
        if (mst_addr >= 32'd768) per_val <= per_val + 32'd1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input bit en, input logic [1:0] dir, input bit sinc,
      input bit dinc, input logic [1:0] ss, input logic [1:0] ds, input bit circ,
      input bit direct, input logic [1:0] th, input logic [2:0] ch);
    return {16'd0, ch, th, direct, circ, ds, ss, dinc, sinc, dir, en};
  endfunction

  task automatic cfg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic launch(input int src, input int dst, input int cnt, input logic [31:0] c);
    cfg(3'd0, 32'(src));
    cfg(3'd1, 32'(dst));
    cfg(3'd2, 32'(cnt));
    cfg(3'd3, c);
  endtask

  task automatic pulse(input int line);
    @(negedge clk); per_req[line] = 1'b1;
    @(negedge clk); per_req[line] = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && active; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_tc();
    for (int i = 0; i < 400 && !tc_flag; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 active", 32'(active), 0);
    chk("R1 tc_flag", 32'(tc_flag), 0);
    chk("R1 arb_req", 32'(arb_req), 0);
    chk("R1 mst_valid", 32'(mst_valid), 0);
  endtask

  task automatic t_m2m();
    int o0 = opn;
    logic [11:0] pat = '0;
    launch(32'h040, 32'h100, 6, mk_ctrl(1, 2'd2, 1, 1, 2'd2, 2'd2, 0, 0, 2'd1, 3'd0));
    wait_idle();
    for (int k = 0; k < 6; k++)
      chk("R6 m2m dst word", rd_word(32'h100 + 4*k), exp_word(32'h040 + 4*k));
    for (int k = 0; k < 12; k++) pat[k] = oplog[8'(o0 + k)];
    chk("R6 fill/drain order", 32'(pat), 32'hCCC);
    chk("R9 tc set", 32'(tc_flag), 1);
    chk("R9 stopped", 32'(active), 0);
    cfg(3'd4, 0);
    chk("R10 tc cleared", 32'(tc_flag), 0);
  endtask

  task automatic t_pack();
    launch(32'h080, 32'h140, 8, mk_ctrl(1, 2'd2, 1, 1, 2'd0, 2'd2, 0, 0, 2'd0, 3'd0));
    wait_idle();
    chk("R8 packed word0", rd_word(32'h140), exp_word(32'h080));
    chk("R8 packed word1", rd_word(32'h144), exp_word(32'h084));
    cfg(3'd4, 0);
    launch(32'h0A0, 32'h1C0, 3, mk_ctrl(1, 2'd2, 1, 0, 2'd2, 2'd2, 0, 0, 2'd0, 3'd0));
    wait_idle();
    chk("R8 fixed dst last", rd_word(32'h1C0), exp_word(32'h0A8));
    chk("R8 fixed dst neighbour", rd_word(32'h1C4), exp_word(32'h1C4));
    cfg(3'd4, 0);
  endtask

  task automatic t_p2m();
    int r0 = rd_cnt, w0 = wr_cnt;
    logic [31:0] pv0 = per_val;
    launch(32'h300, 32'h200, 4, mk_ctrl(1, 2'd0, 0, 1, 2'd2, 2'd2, 0, 0, 2'd3, 3'd5));
    pulse(3); pulse(3);
    chk("R2 wrong line no read", 32'(rd_cnt - r0), 0);
    pulse(5); pulse(5); pulse(5);
    chk("R3 reads per request", 32'(rd_cnt - r0), 3);
    chk("R3 no write below threshold", 32'(wr_cnt - w0), 0);
    pulse(5);
    wait_idle();
    chk("R3 drained at threshold", 32'(wr_cnt - w0), 4);
    for (int k = 0; k < 4; k++)
      chk("R3 p2m data", rd_word(32'h200 + 4*k), pv0 + 32'(k));
    chk("R9 p2m done", 32'(tc_flag), 1);
    cfg(3'd4, 0);
  endtask

  task automatic t_direct();
    int r0 = rd_cnt, w0 = wr_cnt;
    logic [31:0] pv0 = per_val;
    launch(32'h300, 32'h220, 2, mk_ctrl(1, 2'd0, 0, 1, 2'd2, 2'd2, 0, 1, 2'd3, 3'd2));
    pulse(2);
    chk("R4 one read", 32'(rd_cnt - r0), 1);
    chk("R4 written at once", 32'(wr_cnt - w0), 1);
    chk("R4 direct data", rd_word(32'h220), pv0);
    pulse(2);
    wait_idle();
    chk("R4 direct second", rd_word(32'h224), pv0 + 32'd1);
    cfg(3'd4, 0);
  endtask

  task automatic t_m2p();
    int r0 = rd_cnt, p0 = pn;
    launch(32'h240, 32'h300, 6, mk_ctrl(1, 2'd1, 1, 0, 2'd2, 2'd2, 0, 0, 2'd0, 3'd1));
    repeat (15) @(negedge clk);
    chk("R5 prefill reads", 32'(rd_cnt - r0), 4);
    chk("R5 no write before request", 32'(pn - p0), 0);
    pulse(1);
    chk("R5 one write per request", 32'(pn - p0), 1);
    chk("R5 first item", plog[8'(p0)], exp_word(32'h240));
    chk("R5 refill", 32'(rd_cnt - r0), 5);
    for (int k = 0; k < 5; k++) pulse(1);
    wait_idle();
    chk("R5 all written", 32'(pn - p0), 6);
    chk("R5 last item", plog[8'(p0 + 5)], exp_word(32'h254));
    chk("R9 m2p stopped", 32'(active), 0);
    cfg(3'd4, 0);
  endtask

  task automatic t_circ();
    int w0 = wr_cnt;
    launch(32'h040, 32'h280, 2, mk_ctrl(1, 2'd2, 1, 1, 2'd2, 2'd2, 1, 0, 2'd0, 3'd0));
    wait_tc();
    cfg(3'd1, 32'h2C0);
    cfg(3'd4, 0);
    wait_tc();
    chk("R10 still running", 32'(active), 1);
    chk("R10 reloaded writes", 32'(wr_cnt - w0 >= 4), 1);
    cfg(3'd3, 32'h0);
    wait_idle();
    chk("R10 stop request", 32'(active), 0);
    chk("R10 tc sticky", 32'(tc_flag), 1);
    chk("R11 dst write ignored", rd_word(32'h2C0), exp_word(32'h2C0));
    chk("R10 circ data0", rd_word(32'h280), exp_word(32'h040));
    chk("R10 circ data1", rd_word(32'h284), exp_word(32'h044));
    cfg(3'd4, 0);
  endtask

  task automatic t_stall();
    int g0 = waitcyc;
    stall_mode = 1'b1;
    launch(32'h060, 32'h2E0, 4, mk_ctrl(1, 2'd2, 1, 1, 2'd2, 2'd2, 0, 0, 2'd1, 3'd0));
    wait_idle();
    stall_mode = 1'b0;
    chk("R7 no access without grant", 32'(nogrant), 0);
    chk("R7 request waited", 32'(waitcyc - g0 > 0), 1);
    for (int k = 0; k < 4; k++)
      chk("R7 stalled copy", rd_word(32'h2E0 + 4*k), exp_word(32'h060 + 4*k));
    cfg(3'd4, 0);
  endtask

  task automatic t_zero();
    int o0 = opn;
    launch(32'h040, 32'h180, 0, mk_ctrl(1, 2'd2, 1, 1, 2'd2, 2'd2, 0, 0, 2'd0, 3'd0));
    repeat (4) @(negedge clk);
    chk("R9 zero count tc", 32'(tc_flag), 1);
    chk("R9 zero count idle", 32'(active), 0);
    chk("R9 zero count no access", 32'(opn - o0), 0);
  endtask

  initial begin
    for (int a = 0; a < 768; a++) bmem[a] = finit(a);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_m2m();
    t_pack();
    t_p2m();
    t_direct();
    t_m2p();
    t_circ();
    t_stall();
    t_zero();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule